// File: doc/BRIEF.md
# Streaming Five-Stage Micro-Core

This block is a very small in-order processor. Instructions move in one direction through five stages: fetch, decode, register read, execute and write back. There is no branch path, no stall, no flush and no operand bypass. The program counter counts up by one on every clock and wraps, so the 16-word program repeats for as long as reset stays low. The only feedback path is the register file. Software must place enough nops between a producer and a consumer for the value to be there in time.

Each 7-bit instruction has an opcode in bits [6:4], a source register index in bits [3:2] and a destination register index in bits [1:0]. The data path is 8 bits wide and the register file has four entries. The program store is loaded through a write port while the core is held in reset. A debug port reads any register with one cycle of latency. That is how the register contents are observed.

Top module: `stream_core`

## Requirements
- R1: The five stages are applied in a fixed order. The instruction fetched on the k-th rising edge after reset is released (k = 1, 2, ...) writes its destination register on edge k+4. An instruction placed three or more slots later reads the new value.
- R2: The instruction fields sit at fixed positions: opcode in bits [6:4], source index in bits [3:2], destination index in bits [1:0].
- R3: The opcode values are 001 for move (dst = src), 010 for move-immediate and 011 for add (dst = dst + src). Opcode 100 is multiply (dst = dst * src).
- R4: Opcode 000 and opcodes 101, 110 and 111 write no register.
- R5: Add and multiply keep only the low 8 bits of the result.
- R6: Move-immediate writes the 2-bit source field to the destination register, zero-extended to 8 bits.
- R7: There is no interlock and no bypass. An instruction placed one or two slots after a writer of its operand reads the value from before that write.
- R8: The program counter steps by one on every clock out of reset and wraps from 15 to 0, so the program re-executes from address 0.
- R9: A synchronous active-high reset sets the program counter to 0, fills every pipeline stage with a nop and clears all four registers and the debug output to 0.
- R10: When the load strobe is high at a rising edge, the load data is written into the program store at the load address.
- R11: The debug output is registered. After each rising edge it holds the value that the register selected by the debug address had just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pgm_we | input | 1 | Program store write strobe |
| pgm_addr | input | 4 | Program store write address |
| pgm_data | input | 7 | Instruction word to write |
| dbg_sel | input | 2 | Register index for the debug read |
| dbg_data | output | 8 | Registered debug read data |

## Verification
Several properties are checked on every cycle by the assertions. The program counter steps by one each cycle and wraps. Reset leaves the write-back stage idle. Nop and undefined opcodes never raise a write. A move forwards its operand unchanged. A move-immediate result has all upper bits at zero. A register write lands in the register file on the following edge.

Other behaviour shows only in the bench scenarios, which run a reference model of the core and compare the debug port on every clock. These cover the exact stage count from fetch to visible result, and stale reads at one and two slots of spacing. They also cover the truncated add and multiply results, the repetition of the program after wrap, and the clearing of the registers by a reset in the middle of a run.

// File: rtl/stream_core_pkg.sv
package stream_core_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_MOV  = 3'd1,
    OP_MOVI = 3'd2,
    OP_ADD  = 3'd3,
    OP_MUL  = 3'd4
  } op_e;

  localparam int DEF_DATA_W = 8;
  localparam int DEF_REG_AW = 2;
  localparam int DEF_PC_W   = 4;

endpackage

// File: rtl/sc_fetch.sv
module sc_fetch #(
  parameter int PC_W    = 4,
  parameter int INSTR_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [PC_W-1:0]    ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  output logic [INSTR_W-1:0] ir_q
);
  localparam int DEPTH = 1 << PC_W;

  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] store_q [DEPTH];

  // free-running address, registered before it reaches the store
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end

  // block-RAM style store: one write port, registered read with sync reset
  always_ff @(posedge clk) begin
    if (ld_we) store_q[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) ir_q <= '0;
    else     ir_q <= store_q[pc_q];
  end

  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pc_q == $past(pc_q) + 1'b1));

  p_pc_reset_r9: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import stream_core_pkg::*;
#(
  parameter int REG_AW  = 2,
  parameter int INSTR_W = OP_W + 2 * REG_AW
) (
  input  logic [INSTR_W-1:0] ir,
  output op_e                op,
  output logic [REG_AW-1:0]  src,
  output logic [REG_AW-1:0]  dst
);
  logic [OP_W-1:0] code;

  assign code = ir[INSTR_W-1 -: OP_W];
  assign src  = ir[2*REG_AW-1 -: REG_AW];
  assign dst  = ir[REG_AW-1:0];

  always_comb begin
    unique case (code)
      3'd1:    op = OP_MOV;
      3'd2:    op = OP_MOVI;
      3'd3:    op = OP_ADD;
      3'd4:    op = OP_MUL;
      default: op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic [REG_AW-1:0] ra_b,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [DATA_W-1:0] dbg_data
);
  localparam int NREG = 1 << REG_AW;

  logic [DATA_W-1:0] rf_q [NREG];

  // combinational reads, no write-through
  assign rd_a = rf_q[ra_a];
  assign rd_b = rf_q[ra_b];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                         rf_q[g] <= '0;
        else if (we && (wa == REG_AW'(g))) rf_q[g] <= wd;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= rf_q[dbg_sel];
  end

  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> (rf_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/sc_execute.sv
module sc_execute
  import stream_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [REG_AW-1:0] imm,
  input  logic [REG_AW-1:0] dst,
  output logic              wb_we,
  output logic [REG_AW-1:0] wb_dst,
  output logic [DATA_W-1:0] wb_data
);
  logic [DATA_W-1:0] res;
  logic              wr;

  always_comb begin
    res = '0;
    wr  = 1'b1;
    unique case (op)
      OP_MOV:  res = a;
      OP_MOVI: res = {{(DATA_W-REG_AW){1'b0}}, imm};
      OP_ADD:  res = b + a;
      OP_MUL:  res = b * a;
      default: wr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_we   <= 1'b0;
      wb_dst  <= '0;
      wb_data <= '0;
    end else begin
      wb_we   <= wr;
      wb_dst  <= dst;
      wb_data <= res;
    end
  end

  p_nop_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP) |=> !wb_we);

  p_mov_passes_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOV) |=> (wb_we && wb_data == $past(a)));

  p_movi_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOVI) |=> (wb_data[DATA_W-1:REG_AW] == '0));

endmodule

// File: rtl/stream_core.sv
module stream_core
  import stream_core_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int REG_AW = DEF_REG_AW,
  parameter int PC_W   = DEF_PC_W,
  localparam int INSTR_W = OP_W + 2 * REG_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pgm_we,
  input  logic [PC_W-1:0]    pgm_addr,
  input  logic [INSTR_W-1:0] pgm_data,
  input  logic [REG_AW-1:0]  dbg_sel,
  output logic [DATA_W-1:0]  dbg_data
);
  // stage 1: fetch
  logic [INSTR_W-1:0] ir_q;

  sc_fetch #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_fetch (
    .clk(clk), .rst(rst), .ld_we(pgm_we), .ld_addr(pgm_addr),
    .ld_data(pgm_data), .ir_q(ir_q)
  );

  // stage 2: decode
  op_e               dec_op;
  logic [REG_AW-1:0] dec_src, dec_dst;

  sc_decode #(.REG_AW(REG_AW), .INSTR_W(INSTR_W)) u_dec (
    .ir(ir_q), .op(dec_op), .src(dec_src), .dst(dec_dst)
  );

  op_e               id_op;
  logic [REG_AW-1:0] id_src, id_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_op  <= OP_NOP;
      id_src <= '0;
      id_dst <= '0;
    end else begin
      id_op  <= dec_op;
      id_src <= dec_src;
      id_dst <= dec_dst;
    end
  end

  // stage 3: register read
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              wb_we;
  logic [REG_AW-1:0] wb_dst;
  logic [DATA_W-1:0] wb_data;

  sc_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(id_src), .rd_a(rd_a),
    .ra_b(id_dst), .rd_b(rd_b),
    .we(wb_we), .wa(wb_dst), .wd(wb_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  op_e               rr_op;
  logic [DATA_W-1:0] rr_a, rr_b;
  logic [REG_AW-1:0] rr_imm, rr_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_op  <= OP_NOP;
      rr_a   <= '0;
      rr_b   <= '0;
      rr_imm <= '0;
      rr_dst <= '0;
    end else begin
      rr_op  <= id_op;
      rr_a   <= rd_a;
      rr_b   <= rd_b;
      rr_imm <= id_src;
      rr_dst <= id_dst;
    end
  end

  // stages 4 and 5: execute, then write back through the register file
  sc_execute #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ex (
    .clk(clk), .rst(rst), .op(rr_op), .a(rr_a), .b(rr_b),
    .imm(rr_imm), .dst(rr_dst),
    .wb_we(wb_we), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!wb_we && rr_op == OP_NOP && id_op == OP_NOP));

  p_stage_order_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(id_op) != OP_NOP) |-> (rr_op == $past(id_op)));

endmodule

// File: tb/stream_core_tb_top.sv
`timescale 1ns/1ps
module stream_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pgm_we = 1'b0;
  logic [3:0] pgm_addr = '0;
  logic [6:0] pgm_data = '0;
  logic [1:0] dbg_sel = '0;
  logic [7:0] dbg_data;

  always #2.5 clk = ~clk;

  stream_core dut_i (
    .clk(clk), .rst(rst), .pgm_we(pgm_we), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [6:0] mrom [16];
  int         mregs [4];
  int         q_dst [$];
  int         q_val [$];
  int         q_due [$];
  int         t = 0;
  logic [6:0] prog [16];

  function automatic logic [6:0] enc(int op, int s, int d);
    return {3'(op), 2'(s), 2'(d)};
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int k = 0; k < 4; k++) mregs[k] = 0;
      q_dst.delete(); q_val.delete(); q_due.delete();
      t = 0;
    end else begin
      int i;
      t++;
      i = t - 3;
      if (i >= 0) begin
        logic [6:0] w;
        int op, s, d, v;
        bit wr;
        w = mrom[i % 16];
        op = int'(w[6:4]); s = int'(w[3:2]); d = int'(w[1:0]);
        wr = 1'b1; v = 0;
        case (op)
          1: v = mregs[s];
          2: v = s;
          3: v = (mregs[d] + mregs[s]) % 256;
          4: v = (mregs[d] * mregs[s]) % 256;
          default: wr = 1'b0;
        endcase
        if (wr) begin
          q_dst.push_back(d); q_val.push_back(v); q_due.push_back(t + 2);
        end
      end
      if (q_due.size() > 0 && q_due[0] == t) begin
        mregs[q_dst[0]] = q_val[0];
        void'(q_dst.pop_front()); void'(q_val.pop_front()); void'(q_due.pop_front());
      end
    end
  endtask

  // called just after a falling edge; runs one clock
  task automatic cycle(string tg);
    int exp_v;
    if (rst) begin
      if (pgm_we) mrom[pgm_addr] = pgm_data;
      exp_v = 0;
    end else begin
      exp_v = mregs[dbg_sel];
    end
    model_edge();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(dbg_data) != exp_v) begin
      errors++;
      $display("FAIL %s R11 dbg r%0d actual %0d expected %0d t=%0d",
               tg, dbg_sel, dbg_data, exp_v, t);
    end
    dbg_sel = dbg_sel + 2'd1;
  endtask

  task automatic run_prog(string tg, int ncyc);
    rst = 1'b1;
    cycle("R9");
    for (int a = 0; a < 16; a++) begin
      pgm_we = 1'b1; pgm_addr = 4'(a); pgm_data = prog[a];
      cycle("R10/R9");
    end
    pgm_we = 1'b0;
    cycle("R9");
    rst = 1'b0;
    for (int c = 0; c < ncyc; c++) cycle(tg);
  endtask

  initial begin
    @(negedge clk);

    // R2/R3/R6/R1: moves, immediates, arithmetic with safe spacing
    for (int a = 0; a < 16; a++) prog[a] = enc(0, 0, 0);
    prog[0] = enc(2, 3, 0); prog[1] = enc(2, 1, 1); prog[2] = enc(2, 2, 2);
    prog[4] = enc(1, 0, 3); prog[7] = enc(3, 1, 3); prog[8] = enc(4, 0, 2);
    prog[11] = enc(1, 3, 1);
    run_prog("R1/R2/R3/R6", 60);

    // R7: consumers at one, two and three slots after a producer
    for (int a = 0; a < 16; a++) prog[a] = enc(0, 0, 0);
    prog[0] = enc(2, 3, 0); prog[1] = enc(3, 0, 1); prog[2] = enc(3, 0, 2);
    prog[3] = enc(3, 0, 3); prog[4] = enc(2, 1, 0); prog[5] = enc(1, 0, 1);
    prog[6] = enc(1, 0, 2); prog[7] = enc(1, 0, 3);
    run_prog("R7", 60);

    // R4: undefined opcodes and nop never write
    for (int a = 0; a < 16; a++) prog[a] = enc(0, 0, 0);
    prog[0] = enc(2, 2, 0); prog[1] = enc(2, 1, 3);
    prog[4] = enc(5, 1, 0); prog[5] = enc(6, 2, 1); prog[6] = enc(7, 3, 2);
    prog[7] = enc(0, 3, 3); prog[8] = enc(7, 0, 0); prog[9] = enc(5, 3, 3);
    run_prog("R4", 50);

    // R5/R8: overflowing products and sums, program repeats after wrap
    for (int a = 0; a < 16; a++) prog[a] = enc(0, 0, 0);
    prog[0] = enc(2, 3, 0); prog[1] = enc(2, 3, 1);
    prog[4] = enc(4, 0, 1); prog[7] = enc(4, 1, 1);
    prog[10] = enc(3, 1, 2); prog[13] = enc(3, 2, 3); prog[14] = enc(4, 1, 3);
    run_prog("R5/R8", 90);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule